// File: doc/BRIEF.md
# Memory Region Security Filter

This block decides, for each memory access, whether a non-secure requester may reach the target address. Eight programmable windows, each with a start and an end in 1 MB units, can be marked protected one by one. A further switch protects every address that lies outside all eight windows. A global bypass opens the whole address space at once.

Configuration arrives over a simple 32-bit write port. The upper half-word is a per-bit write mask for the lower half-word, so software can change single fields without a read-modify-write. Register indices 0 to 7 hold the window starts, 8 to 15 hold the window ends, and index 16 holds the control word. A combinational read port returns any configuration register.

A lookup presents an address and a non-secure flag. The permit/deny decision is registered and comes out one clock later, together with a valid strobe. There is no state machine: the lookup is a one-stage pipeline, and the configuration is plain registers.

Top module: `sec_flt_top`

## Requirements
- R1: After reset every window bound reads 0, the control word (index 16) reads 0x0200 (bypass set, all enables clear), and res_valid and res_deny are 0.
- R2: On a write, data bit i (0 to 15) of the addressed register changes only when wdata bit 16+i is 1. Bits whose mask bit is 0 keep their old value.
- R3: Index n (0 to 7) is the start of window n, index n+8 is its end, and index 16 is the control word. Writes to an index above 16 change nothing, and reads from such an index return 0. Control bits 15:10 always read 0.
- R4: An address falls in window n when start_n <= addr[31:20] <= end_n. Both bounds are inclusive, so start 0 with end 31 covers [0, 32 MB).
- R5: Control bit n (0 to 7) enables window n. A non-secure lookup that falls in an enabled window is denied unless bypass is set.
- R6: Control bit 8 protects the remainder: a non-secure lookup that falls in none of the eight windows is denied when bit 8 is 1 and bypass is 0. A lookup that falls only in disabled windows is not in the remainder and is permitted.
- R7: Control bit 9 is the global bypass. While it is 1, no lookup is denied.
- R8: A lookup with the non-secure flag at 0 is always permitted.
- R9: A window whose start is greater than its end covers no address.
- R10: res_valid is 1 exactly one clock after lk_valid was 1. res_deny is 0 whenever res_valid is 0. A configuration write takes effect for lookups presented in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 5 | Register index for the write |
| cfg_wdata | input | 32 | Write mask in 31:16, data in 15:0 |
| rd_idx | input | 5 | Register index for readback |
| rd_data | output | 16 | Readback value of register rd_idx |
| lk_valid | input | 1 | Lookup request strobe |
| lk_addr | input | 32 | Byte address of the access |
| lk_ns | input | 1 | 1 for a non-secure access |
| res_valid | output | 1 | Lookup result valid, one clock after lk_valid |
| res_deny | output | 1 | 1 when the access must be blocked |

## Verification
The bound checker tests, on every cycle, the one-clock result latency, that deny only appears with valid, that secure lookups and lookups under bypass are never denied, that a hit in an enabled window or a miss of every window with remainder protection forces deny, and that masked-off or out-of-range control writes leave the enables and bypass alone. The write-mask merge on the bound registers, the inclusive edges of a window, the reset values and the behaviour of an inverted window are shown only through the bench's scenarios, which read registers back and run lookups at the exact boundary megabytes.

// File: rtl/sec_flt_pkg.sv
package sec_flt_pkg;

    // Width of one configuration half-word and of a bound value
    localparam int REG_DW    = 16;
    // Byte address width and the shift that turns a byte address into a megabyte number
    localparam int ADDR_W    = 32;
    localparam int MB_SHIFT  = 20;
    // Default number of programmable windows
    localparam int DEF_NRGN  = 8;

    // Masked half-word merge: data bit taken only where the mask bit is 1
    function automatic logic [REG_DW-1:0] masked_merge(
        input logic [REG_DW-1:0] old_v,
        input logic [REG_DW-1:0] new_v,
        input logic [REG_DW-1:0] msk
    );
        return (old_v & ~msk) | (new_v & msk);
    endfunction

endpackage

// File: rtl/sec_flt_cfg.sv
module sec_flt_cfg
    import sec_flt_pkg::*;
#(
    parameter int NUM_RGN = DEF_NRGN,
    parameter int IDX_W   = $clog2(2*NUM_RGN+1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [2*REG_DW-1:0]         wr_word,
    input  logic [IDX_W-1:0]            rd_idx,
    output logic [REG_DW-1:0]           rd_val,
    output logic [NUM_RGN*REG_DW-1:0]   lo_flat,
    output logic [NUM_RGN*REG_DW-1:0]   hi_flat,
    output logic [NUM_RGN-1:0]          win_en,
    output logic                        rem_en,
    output logic                        byp
);

    localparam int CTL_IDX = 2*NUM_RGN;
    localparam int REM_BIT = NUM_RGN;
    localparam int BYP_BIT = NUM_RGN + 1;
    localparam int CTL_W   = NUM_RGN + 2;

    logic [REG_DW-1:0] wr_dat;
    logic [REG_DW-1:0] wr_msk;
    logic [REG_DW-1:0] lo_q [NUM_RGN];
    logic [REG_DW-1:0] hi_q [NUM_RGN];
    logic [CTL_W-1:0]  ctl_q;
    logic [REG_DW-1:0] ctl_full;

    assign wr_dat = wr_word[REG_DW-1:0];
    assign wr_msk = wr_word[2*REG_DW-1:REG_DW];

    // Window bound registers, one pair per window
    for (genvar g = 0; g < NUM_RGN; g++) begin : g_win
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lo_q[g] <= '0;
            end else if (wr_en && (int'(wr_idx) == g)) begin
                lo_q[g] <= masked_merge(lo_q[g], wr_dat, wr_msk);
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hi_q[g] <= '0;
            end else if (wr_en && (int'(wr_idx) == g + NUM_RGN)) begin
                hi_q[g] <= masked_merge(hi_q[g], wr_dat, wr_msk);
            end
        end

        assign lo_flat[g*REG_DW +: REG_DW] = lo_q[g];
        assign hi_flat[g*REG_DW +: REG_DW] = hi_q[g];
    end

    // Control word: window enables, remainder enable, bypass (bypass set at reset)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= CTL_W'(1) << BYP_BIT;
        end else if (wr_en && (int'(wr_idx) == CTL_IDX)) begin
            ctl_q <= (ctl_q & ~wr_msk[CTL_W-1:0]) | (wr_dat[CTL_W-1:0] & wr_msk[CTL_W-1:0]);
        end
    end

    assign ctl_full = REG_DW'(ctl_q);
    assign win_en   = ctl_q[NUM_RGN-1:0];
    assign rem_en   = ctl_q[REM_BIT];
    assign byp      = ctl_q[BYP_BIT];

    // Readback multiplexer
    always_comb begin
        rd_val = '0;
        if (int'(rd_idx) < NUM_RGN) begin
            rd_val = lo_q[int'(rd_idx)];
        end else if (int'(rd_idx) < CTL_IDX) begin
            rd_val = hi_q[int'(rd_idx) - NUM_RGN];
        end else if (int'(rd_idx) == CTL_IDX) begin
            rd_val = ctl_full;
        end
    end

endmodule

// File: rtl/sec_flt_match.sv
module sec_flt_match
    import sec_flt_pkg::*;
#(
    parameter int NUM_RGN = DEF_NRGN
) (
    input  logic [ADDR_W-1:0]           addr,
    input  logic [NUM_RGN*REG_DW-1:0]   lo_flat,
    input  logic [NUM_RGN*REG_DW-1:0]   hi_flat,
    output logic [NUM_RGN-1:0]          in_win
);

    localparam int MB_W = ADDR_W - MB_SHIFT;

    logic [MB_W-1:0]   addr_mb;
    logic [REG_DW-1:0] addr_mb_x;

    assign addr_mb   = addr[ADDR_W-1:MB_SHIFT];
    assign addr_mb_x = REG_DW'(addr_mb);

    // Inclusive range compare per window; an inverted window never matches
    for (genvar g = 0; g < NUM_RGN; g++) begin : g_cmp
        logic [REG_DW-1:0] lo_v;
        logic [REG_DW-1:0] hi_v;
        assign lo_v      = lo_flat[g*REG_DW +: REG_DW];
        assign hi_v      = hi_flat[g*REG_DW +: REG_DW];
        assign in_win[g] = (addr_mb_x >= lo_v) && (addr_mb_x <= hi_v);
    end

endmodule

// File: rtl/sec_flt_top.sv
module sec_flt_top
    import sec_flt_pkg::*;
#(
    parameter int NUM_RGN = DEF_NRGN,
    parameter int IDX_W   = $clog2(2*NUM_RGN+1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic [31:0]        cfg_wdata,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [15:0]        rd_data,
    input  logic               lk_valid,
    input  logic [31:0]        lk_addr,
    input  logic               lk_ns,
    output logic               res_valid,
    output logic               res_deny
);

    logic [NUM_RGN*REG_DW-1:0] lo_flat;
    logic [NUM_RGN*REG_DW-1:0] hi_flat;
    logic [NUM_RGN-1:0]        win_en;
    logic                      rem_en;
    logic                      byp;
    logic [NUM_RGN-1:0]        in_win;
    logic                      prot_hit;
    logic                      deny_d;

    sec_flt_cfg #(
        .NUM_RGN (NUM_RGN),
        .IDX_W   (IDX_W)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_idx  (cfg_idx),
        .wr_word (cfg_wdata),
        .rd_idx  (rd_idx),
        .rd_val  (rd_data),
        .lo_flat (lo_flat),
        .hi_flat (hi_flat),
        .win_en  (win_en),
        .rem_en  (rem_en),
        .byp     (byp)
    );

    sec_flt_match #(
        .NUM_RGN (NUM_RGN)
    ) u_match (
        .addr    (lk_addr),
        .lo_flat (lo_flat),
        .hi_flat (hi_flat),
        .in_win  (in_win)
    );

    // Protected when inside an enabled window, or outside every window with remainder set
    assign prot_hit = (|(in_win & win_en)) || ((~|in_win) && rem_en);
    assign deny_d   = lk_valid && lk_ns && !byp && prot_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_deny  <= 1'b0;
        end else begin
            res_valid <= lk_valid;
            res_deny  <= deny_d;
        end
    end

endmodule

// File: rtl/sec_flt_chk.sv
module sec_flt_chk #(
    parameter int NUM_RGN = 8,
    parameter int IDX_W   = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_we,
    input logic [IDX_W-1:0]   cfg_idx,
    input logic [31:0]        cfg_wdata,
    input logic               lk_valid,
    input logic               lk_ns,
    input logic               res_valid,
    input logic               res_deny,
    input logic [NUM_RGN-1:0] win_en,
    input logic               rem_en,
    input logic               byp,
    input logic [NUM_RGN-1:0] in_win
);

    localparam int CTL_IDX = 2*NUM_RGN;
    localparam int BYP_BIT = NUM_RGN + 1;

    p_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid);

    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !res_valid);

    p_deny_vld_r10: assert property (@(posedge clk) disable iff (!rst_n)
        res_deny |-> res_valid);

    p_secure_ok_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_ns) |=> !res_deny);

    p_bypass_ok_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && byp) |=> !res_deny);

    p_win_deny_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_ns && !byp && (|(in_win & win_en))) |=> res_deny);

    p_rem_deny_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_ns && !byp && rem_en && !(|in_win)) |=> res_deny);

    p_byp_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (int'(cfg_idx) == CTL_IDX) && !cfg_wdata[16+BYP_BIT]) |=> $stable(byp));

    p_bad_idx_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (int'(cfg_idx) > CTL_IDX)) |=> ($stable(byp) && $stable(rem_en) && $stable(win_en)));

endmodule

bind sec_flt_top sec_flt_chk #(
    .NUM_RGN (NUM_RGN),
    .IDX_W   (IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_idx   (cfg_idx),
    .cfg_wdata (cfg_wdata),
    .lk_valid  (lk_valid),
    .lk_ns     (lk_ns),
    .res_valid (res_valid),
    .res_deny  (res_deny),
    .win_en    (win_en),
    .rem_en    (rem_en),
    .byp       (byp),
    .in_win    (in_win)
);

// File: tb/sec_flt_top_bench.sv
`timescale 1ns/1ps
module sec_flt_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic [4:0]  rd_idx = '0;
    logic [15:0] rd_data;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        lk_ns = 1'b0;
    logic        res_valid;
    logic        res_deny;

    int n_vec  = 0;
    int n_fail = 0;
    bit exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    sec_flt_top u_sec_flt_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data),
        .lk_valid  (lk_valid),
        .lk_addr   (lk_addr),
        .lk_ns     (lk_ns),
        .res_valid (res_valid),
        .res_deny  (res_deny)
    );

    task automatic wr(input int idx, input logic [31:0] w);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_idx   = 5'(idx);
        cfg_wdata = w;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic rd_chk(input int idx, input logic [15:0] exp, input string req);
        rd_idx = 5'(idx);
        #1;
        n_vec++;
        if (rd_data !== exp) begin
            n_fail++;
            $display("FAIL %s reg %0d: got %h expected %h", req, idx, rd_data, exp);
        end
    endtask

    // Driver: present one lookup for one cycle and queue its expected result
    task automatic look(input logic [31:0] a, input logic ns, input bit exp, input string req);
        @(negedge clk);
        lk_valid = 1'b1;
        lk_addr  = a;
        lk_ns    = ns;
        exp_q.push_back(exp);
        tag_q.push_back(req);
    endtask

    task automatic idle();
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    // Monitor: compares each result against the queue; no deny without valid (R10)
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (res_valid) begin
                    n_vec++;
                    if (exp_q.size() == 0) begin
                        n_fail++;
                        $display("FAIL R10 unexpected result: got valid=1 expected valid=0");
                    end else begin
                        bit e;
                        string t;
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        if (res_deny !== e) begin
                            n_fail++;
                            $display("FAIL %s deny: got %0b expected %0b", t, res_deny, e);
                        end
                    end
                end else if (res_deny !== 1'b0) begin
                    n_vec++;
                    n_fail++;
                    $display("FAIL R10 deny without valid: got %0b expected 0", res_deny);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        rd_chk(16, 16'h0200, "R1");
        rd_chk(0,  16'h0000, "R1");
        rd_chk(15, 16'h0000, "R1");
        n_vec++;
        if (res_valid !== 1'b0 || res_deny !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 outputs: got %0b%0b expected 00", res_valid, res_deny);
        end
        rst_n = 1'b1;

        // R7: bypass open after reset
        look(32'h0000_0000, 1'b1, 1'b0, "R7");
        idle();

        // R2: clear bypass only; enable bit 0 has data 1 but mask 0
        wr(16, 32'h0200_0001);
        rd_chk(16, 16'h0000, "R2");

        // Window 0 = [0, 31] MB, enabled
        wr(0, 32'hFFFF_0000);
        wr(8, 32'hFFFF_001F);
        wr(16, 32'h0001_0001);
        rd_chk(8, 16'h001F, "R3");
        rd_chk(16, 16'h0001, "R5");
        look(32'h01FF_FFFF, 1'b1, 1'b1, "R4");
        look(32'h0200_0000, 1'b1, 1'b0, "R4");
        look(32'h0000_0000, 1'b1, 1'b1, "R5");
        look(32'h0000_0000, 1'b0, 1'b0, "R8");
        idle();

        // R2: partial mask on window 1 start: only low byte taken
        wr(1, 32'h00FF_1234);
        rd_chk(1, 16'h0034, "R2");
        wr(9, 32'hFFFF_0040);
        // Remainder on, window 1 stays disabled
        wr(16, 32'h0100_0100);
        rd_chk(16, 16'h0101, "R6");
        look(32'h0380_0000, 1'b1, 1'b0, "R6");
        look(32'h1000_0000, 1'b1, 1'b1, "R6");
        look(32'h1000_0000, 1'b0, 1'b0, "R8");
        look(32'h0100_0000, 1'b1, 1'b1, "R5");
        idle();

        // R3: out-of-range index and reserved control bits
        wr(17, 32'hFFFF_FFFF);
        rd_chk(16, 16'h0101, "R3");
        rd_chk(17, 16'h0000, "R3");
        wr(16, 32'hFC00_FC00);
        rd_chk(16, 16'h0101, "R3");

        // R9: inverted window 2 (start 0x80 > end 0x70), enabled; remainder off
        wr(2,  32'hFFFF_0080);
        wr(10, 32'hFFFF_0070);
        wr(16, 32'h0104_0004);
        rd_chk(16, 16'h0005, "R9");
        look(32'h0750_0000, 1'b1, 1'b0, "R9");
        look(32'h0800_0000, 1'b1, 1'b0, "R9");
        look(32'h0700_0000, 1'b1, 1'b0, "R9");
        idle();

        // R10: write then lookup on the very next cycle sees new config
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 5'd16; cfg_wdata = 32'h0100_0100;
        @(negedge clk);
        cfg_we = 1'b0;
        lk_valid = 1'b1; lk_addr = 32'h0750_0000; lk_ns = 1'b1;
        exp_q.push_back(1'b1); tag_q.push_back("R10");
        idle();

        // R7: bypass back on, enabled-window hit permitted
        wr(16, 32'h0200_0200);
        rd_chk(16, 16'h0305, "R7");
        look(32'h0010_0000, 1'b1, 1'b0, "R7");
        look(32'hFFF0_0000, 1'b1, 1'b0, "R7");
        idle();

        // R10: back-to-back stream with bypass off
        wr(16, 32'h0200_0000);
        look(32'h0010_0000, 1'b1, 1'b1, "R10");
        look(32'h0010_0000, 1'b0, 1'b0, "R10");
        look(32'hFFF0_0000, 1'b1, 1'b1, "R10");
        look(32'h0380_0000, 1'b1, 1'b0, "R10");
        idle();

        repeat (4) @(negedge clk);
        n_vec++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R10 missing results: got %0d pending expected 0", exp_q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule